// File: doc/BRIEF.md
# Trap Priority and Conflict Controller

This block sits beside a processor core and gathers its non-maskable trap requests: an arithmetic fault, an address fault, a stack fault and an oscillator-failure event. Each request is latched as pending. The controller picks the most urgent pending trap, gives its vector index and priority level to the core, and tracks which traps are in service until the core signals that each handler has returned. Levels 8 to 11 form the soft class and levels 12 to 15 form the hard class. The arithmetic fault sits at level 11. The address, stack and oscillator faults sit at levels 12, 13 and 14. Level 15 has no source.

Hard traps halt the core until it takes them. A soft trap lets execution continue, and any hard trap may preempt it. A hard trap that arrives while a higher hard trap is still pending or in service is a conflict. On a conflict the block flushes all its trap state, sends out a one-cycle device reset request and sets a sticky flag. The flag survives that reset so that software can find the cause, and only a written zero clears it.

Top module: `trap_ctrl`

## Requirements
- R1: After reset, trap_valid, cpu_stall, rst_req and trap_rst_flag are all 0.
- R2: A request pulse on trap_req bit s appears as pending on the next cycle. Bit 0 is the arithmetic fault, bit 1 the address fault, bit 2 the stack fault and bit 3 the oscillator failure, at levels 11, 12, 13 and 14 in that order. trap_level gives the level and trap_vec gives the level minus 8.
- R3: When several requests arrive in the same cycle from an idle state, none of them causes a conflict. The highest level is presented first, the rest stay pending, and they are presented in descending level order as each one is acknowledged and completed.
- R4: cpu_stall is 1 from the cycle after a hard request is latched, and it stays 1 for as long as any hard trap is pending and not yet acknowledged. It drops in the cycle after the last such trap is acknowledged.
- R5: A pending soft trap never raises cpu_stall.
- R6: A hard request that arrives while a soft trap is pending or in service is presented, and it causes no conflict.
- R7: A pending trap is presented only if nothing is in service or its level is above the highest level in service.
- R8: A hard request at level L that arrives while a hard trap above L is pending or in service causes a conflict. On the next cycle rst_req is 1 for exactly one cycle, all pending and in-service state is cleared, and trap_rst_flag is 1.
- R9: A hard request that arrives above every pending or in-service hard trap causes no conflict and is presented.
- R10: trap_rst_flag keeps its value through the reset pulse. A status write of 1 leaves it unchanged and a status write of 0 clears it. A conflict in the same cycle as a write of 0 leaves the flag at 1.
- R11: A trap_ack pulse while trap_valid is 0 changes no state.
- R12: A trap_done pulse takes only the highest in-service trap out of service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_req | input | 4 | Per-source request pulses: arithmetic, address, stack, oscillator |
| trap_ack | input | 1 | Core takes the presented trap |
| trap_done | input | 1 | Core has returned from the highest in-service handler |
| trap_valid | output | 1 | A trap is presented |
| trap_vec | output | 3 | Vector index of the presented trap |
| trap_level | output | 4 | Priority level of the presented trap |
| cpu_stall | output | 1 | Halts execution while a hard trap is unacknowledged |
| rst_req | output | 1 | One-cycle device reset request on a conflict |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 1 | Status write data; 0 clears the flag |
| trap_rst_flag | output | 1 | Sticky flag: a conflict reset took place |

## Verification
The bench builds the block with its default parameters: eight levels from a base of 8, four sources and the hard class starting at index 4. With only fifteen possible request patterns, it sweeps every one of them from idle. For each pattern it works out the descending service order, the stall level and the blocking by in-service traps. It also sweeps every ordered pair of hard sources with the first one either pending or in service, which covers each case of a conflict or a clean preemption. Directed runs cover soft preemption, an ignored acknowledge and the write rules of the sticky flag.

// File: rtl/trap_pkg.sv
// Package trap_pkg
// Holds the default sizing shared by the trap controller and its checker.
// Assumes a trap level range that starts at a fixed base and contains one
// contiguous soft class below one contiguous hard class.
package trap_pkg;
    localparam int TP_LEVELS     = 8;   // number of levels in the trap range
    localparam int TP_BASE       = 8;   // level number of range index 0
    localparam int TP_HARD_FIRST = 4;   // first index of the hard class
    localparam int TP_NSRC       = 4;   // number of request sources
endpackage

// File: rtl/trap_prio_enc.sv
// Module trap_prio_enc
// Finds the highest set bit of a vector and reports its index.
// Assumes IW is wide enough to hold W-1; idx is 0 when found is 0.
module trap_prio_enc #(
    parameter int W  = 8,
    parameter int IW = 3
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan upward so that the highest set bit wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/trap_pend_bank.sv
// Module trap_pend_bank
// Maps the source request lines onto level indices and holds one pending
// bit per level. A request sets its bit, an acknowledge clears it, and a
// flush clears every bit. A new request wins over a clear of the same bit.
// Assumes that SRC_MAP holds one IW-bit level index per source.
module trap_pend_bank #(
    parameter int                      LEVELS  = 8,
    parameter int                      NUM_SRC = 4,
    parameter int                      IW      = 3,
    parameter logic [NUM_SRC*IW-1:0]   SRC_MAP = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic [NUM_SRC-1:0] req,
    input  logic               clr_en,
    input  logic [IW-1:0]      clr_idx,
    output logic [LEVELS-1:0]  arrive,
    output logic [LEVELS-1:0]  pend
);
    // Route each source request onto its level.
    always_comb begin
        arrive = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (req[s]) arrive[SRC_MAP[s*IW +: IW]] = 1'b1;
        end
    end

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        logic clr_hit;
        assign clr_hit = clr_en && (clr_idx == IW'(l));

        // Pending flop for one level: flush, then set, then clear.
        always_ff @(posedge clk) begin
            if (!rst_n)            pend[l] <= 1'b0;
            else if (flush)        pend[l] <= 1'b0;
            else if (arrive[l])    pend[l] <= 1'b1;
            else if (clr_hit)      pend[l] <= 1'b0;
        end
    end
endmodule

// File: rtl/trap_svc_track.sv
// Module trap_svc_track
// Records the levels whose handlers are running. An acknowledge marks a
// level in service. A completion strobe ends the highest one in service.
// Assumes that completion strobes come only while something is in service;
// a spare strobe has no effect.
module trap_svc_track #(
    parameter int LEVELS = 8,
    parameter int IW     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              set_en,
    input  logic [IW-1:0]     set_idx,
    input  logic              done,
    output logic [LEVELS-1:0] in_svc,
    output logic              svc_any,
    output logic [IW-1:0]     svc_top
);
    logic [LEVELS-1:0] in_svc_n;

    trap_prio_enc #(.W(LEVELS), .IW(IW)) u_top (
        .vec   (in_svc),
        .found (svc_any),
        .idx   (svc_top)
    );

    // Next in-service set: end the highest level, then add the new one.
    always_comb begin
        in_svc_n = in_svc;
        if (done && svc_any) in_svc_n[svc_top] = 1'b0;
        if (set_en)          in_svc_n[set_idx] = 1'b1;
    end

    // In-service register with flush.
    always_ff @(posedge clk) begin
        if (!rst_n)     in_svc <= '0;
        else if (flush) in_svc <= '0;
        else            in_svc <= in_svc_n;
    end
endmodule

// File: rtl/trap_conflict_det.sv
// Module trap_conflict_det
// Flags a hard-class conflict when a new hard request arrives below the
// highest hard level that is already pending or in service.
// Assumes that both inputs hold only the hard-class slice, index 0 being the
// lowest hard level.
module trap_conflict_det #(
    parameter int NH  = 4,
    parameter int NIW = 2
) (
    input  logic [NH-1:0] arrive_hard,
    input  logic [NH-1:0] busy_hard,
    output logic          conflict
);
    logic           busy_found;
    logic [NIW-1:0] busy_top;
    logic [NH-1:0]  below;

    trap_prio_enc #(.W(NH), .IW(NIW)) u_busy (
        .vec   (busy_hard),
        .found (busy_found),
        .idx   (busy_top)
    );

    for (genvar j = 0; j < NH; j++) begin : g_below
        assign below[j] = busy_found && (NIW'(j) < busy_top);
    end

    // A conflict is any arrival strictly below the busiest hard level.
    assign conflict = |(arrive_hard & below);
endmodule

// File: rtl/trap_ctrl.sv
// Module trap_ctrl
// Top of the trap priority and conflict controller. It latches trap
// requests, presents the highest eligible trap to the core, tracks traps in
// service, stalls the core while a hard trap is unacknowledged, and on a
// hard-class conflict flushes its state, pulses a reset request and sets a
// sticky flag that only a written zero clears.
// Assumes that trap_req bits are single-cycle pulses and that the core
// drives trap_ack only for the trap shown while trap_valid is high.
module trap_ctrl
    import trap_pkg::*;
#(
    parameter int LEVELS     = TP_LEVELS,
    parameter int LEVEL_BASE = TP_BASE,
    parameter int HARD_FIRST = TP_HARD_FIRST,
    parameter int NUM_SRC    = TP_NSRC,
    parameter int IDX_W      = $clog2(LEVELS),
    parameter int LVL_W      = $clog2(LEVEL_BASE + LEVELS),
    parameter logic [NUM_SRC*IDX_W-1:0] SRC_MAP = {3'd6, 3'd5, 3'd4, 3'd3}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] trap_req,
    input  logic               trap_ack,
    input  logic               trap_done,
    output logic               trap_valid,
    output logic [IDX_W-1:0]   trap_vec,
    output logic [LVL_W-1:0]   trap_level,
    output logic               cpu_stall,
    output logic               rst_req,
    input  logic               sts_wr,
    input  logic               sts_wdata,
    output logic               trap_rst_flag
);
    localparam int NH  = LEVELS - HARD_FIRST;
    localparam int NIW = (NH > 1) ? $clog2(NH) : 1;

    logic [LEVELS-1:0] arrive;
    logic [LEVELS-1:0] pend;
    logic [LEVELS-1:0] in_svc;
    logic              p_found;
    logic [IDX_W-1:0]  p_idx;
    logic              svc_any;
    logic [IDX_W-1:0]  svc_top;
    logic              present;
    logic              ack_fire;
    logic              conflict;
    logic [LEVELS-1:0] busy;

    trap_pend_bank #(
        .LEVELS  (LEVELS),
        .NUM_SRC (NUM_SRC),
        .IW      (IDX_W),
        .SRC_MAP (SRC_MAP)
    ) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (conflict),
        .req     (trap_req),
        .clr_en  (ack_fire),
        .clr_idx (p_idx),
        .arrive  (arrive),
        .pend    (pend)
    );

    trap_prio_enc #(.W(LEVELS), .IW(IDX_W)) u_psel (
        .vec   (pend),
        .found (p_found),
        .idx   (p_idx)
    );

    trap_svc_track #(.LEVELS(LEVELS), .IW(IDX_W)) u_svc (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (conflict),
        .set_en  (ack_fire),
        .set_idx (p_idx),
        .done    (trap_done),
        .in_svc  (in_svc),
        .svc_any (svc_any),
        .svc_top (svc_top)
    );

    // Levels that block lower hard arrivals: pending or in service.
    assign busy = pend | in_svc;

    trap_conflict_det #(.NH(NH), .NIW(NIW)) u_conf (
        .arrive_hard (arrive[LEVELS-1:HARD_FIRST]),
        .busy_hard   (busy[LEVELS-1:HARD_FIRST]),
        .conflict    (conflict)
    );

    // Present the top pending trap only above the level now in service.
    assign present    = p_found && (!svc_any || (p_idx > svc_top));
    assign ack_fire   = trap_ack && present;
    assign trap_valid = present;
    assign trap_vec   = present ? p_idx : '0;
    assign trap_level = present ? (LVL_W'(LEVEL_BASE) + LVL_W'(p_idx)) : '0;

    // Stall while any hard level is pending and not yet taken.
    assign cpu_stall  = |pend[LEVELS-1:HARD_FIRST];

    // Reset request: one cycle after each conflict.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_req <= 1'b0;
        else        rst_req <= conflict;
    end

    // Sticky cause flag: a conflict sets it, a written zero clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                  trap_rst_flag <= 1'b0;
        else if (conflict)           trap_rst_flag <= 1'b1;
        else if (sts_wr && !sts_wdata) trap_rst_flag <= 1'b0;
    end
endmodule

// File: rtl/trap_ctrl_chk.sv
// Module trap_ctrl_chk
// Property checker for trap_ctrl, attached by bind. It sees only the ports.
// Assumes the same source-to-level map as the controller it watches.
module trap_ctrl_chk #(
    parameter int LEVELS     = 8,
    parameter int HARD_FIRST = 4,
    parameter int NUM_SRC    = 4,
    parameter int IDX_W      = 3,
    parameter logic [NUM_SRC*IDX_W-1:0] SRC_MAP = '0
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] trap_req,
    input logic               trap_valid,
    input logic [IDX_W-1:0]   trap_vec,
    input logic               cpu_stall,
    input logic               rst_req,
    input logic               sts_wr,
    input logic               sts_wdata,
    input logic               trap_rst_flag
);
    logic hard_req;
    logic soft_req;
    logic top_free;

    // Split the requests into classes and see whether the top level has a source.
    always_comb begin
        hard_req = 1'b0;
        soft_req = 1'b0;
        top_free = 1'b1;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (int'(SRC_MAP[s*IDX_W +: IDX_W]) >= HARD_FIRST) hard_req = hard_req | trap_req[s];
            else                                               soft_req = soft_req | trap_req[s];
            if (int'(SRC_MAP[s*IDX_W +: IDX_W]) == LEVELS - 1) top_free = 1'b0;
        end
    end

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    a_r8_flag_with_reset: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> trap_rst_flag);

    a_r8_state_flushed: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (!trap_valid && !cpu_stall));

    a_r4_hard_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        hard_req |=> (cpu_stall || rst_req));

    a_r5_soft_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_req && !hard_req && !cpu_stall) |=> !cpu_stall);

    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_rst_flag && !(sts_wr && !sts_wdata)) |=> trap_rst_flag);

    a_r2_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && top_free) |-> (trap_vec != IDX_W'(LEVELS - 1)));
endmodule

bind trap_ctrl trap_ctrl_chk #(
    .LEVELS     (LEVELS),
    .HARD_FIRST (HARD_FIRST),
    .NUM_SRC    (NUM_SRC),
    .IDX_W      (IDX_W),
    .SRC_MAP    (SRC_MAP)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .trap_req      (trap_req),
    .trap_valid    (trap_valid),
    .trap_vec      (trap_vec),
    .cpu_stall     (cpu_stall),
    .rst_req       (rst_req),
    .sts_wr        (sts_wr),
    .sts_wdata     (sts_wdata),
    .trap_rst_flag (trap_rst_flag)
);

// File: tb/sim_trap_ctrl.sv
`timescale 1ns/100ps
// Bench for trap_ctrl: sweeps every request pattern and every hard pair.
module sim_trap_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] trap_req = '0;
    logic       trap_ack = 1'b0;
    logic       trap_done = 1'b0;
    logic       sts_wr = 1'b0;
    logic       sts_wdata = 1'b0;
    logic       trap_valid;
    logic [2:0] trap_vec;
    logic [3:0] trap_level;
    logic       cpu_stall;
    logic       rst_req;
    logic       trap_rst_flag;
    int         n_chk = 0;
    int         n_fail = 0;

    always #2.5 clk = ~clk;

    trap_ctrl u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .trap_req      (trap_req),
        .trap_ack      (trap_ack),
        .trap_done     (trap_done),
        .trap_valid    (trap_valid),
        .trap_vec      (trap_vec),
        .trap_level    (trap_level),
        .cpu_stall     (cpu_stall),
        .rst_req       (rst_req),
        .sts_wr        (sts_wr),
        .sts_wdata     (sts_wdata),
        .trap_rst_flag (trap_rst_flag)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Source s sits at level 11+s, vector 3+s.
    function automatic int top_bit(input logic [3:0] m);
        int t = -1;
        for (int i = 0; i < 4; i++) if (m[i]) t = i;
        return t;
    endfunction

    task automatic pulse_req(input logic [3:0] m);
        trap_req = m;
        @(negedge clk);
        trap_req = '0;
    endtask

    task automatic do_ack();
        trap_ack = 1'b1;
        @(negedge clk);
        trap_ack = 1'b0;
    endtask

    task automatic do_done();
        trap_done = 1'b1;
        @(negedge clk);
        trap_done = 1'b0;
    endtask

    task automatic wr_sts(input logic d);
        sts_wr = 1'b1;
        sts_wdata = d;
        @(negedge clk);
        sts_wr = 1'b0;
    endtask

    task automatic drain();
        for (int k = 0; k < 5; k++) begin
            if (trap_valid) do_ack();
            do_done();
        end
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet after reset.
        check("R1 valid", int'(trap_valid), 0);
        check("R1 stall", int'(cpu_stall), 0);
        check("R1 rst_req", int'(rst_req), 0);
        check("R1 flag", int'(trap_rst_flag), 0);

        // R2 R3 R4 R5 R7 R12: every request pattern from idle.
        for (int m = 1; m < 16; m++) begin
            logic [3:0] rem;
            rem = 4'(m);
            pulse_req(rem);
            check("R3 no conflict", int'(rst_req), 0);
            check("R5 R4 stall on latch", int'(cpu_stall), int'(|rem[3:1]));
            while (rem != 0) begin
                int h;
                h = top_bit(rem);
                check("R3 valid", int'(trap_valid), 1);
                check("R2 vector", int'(trap_vec), h + 3);
                check("R2 level", int'(trap_level), h + 11);
                do_ack();
                rem[h] = 1'b0;
                check("R4 stall after ack", int'(cpu_stall), int'(|rem[3:1]));
                if (rem != 0) check("R7 blocked by service", int'(trap_valid), 0);
                do_done();
            end
            check("R12 idle after last done", int'(trap_valid), 0);
        end

        // R8 R9: every ordered hard pair, first one pending or in service.
        for (int a = 1; a < 4; a++) begin
            for (int b = 1; b < 4; b++) begin
                for (int svc = 0; svc < 2; svc++) begin
                    if (a != b) begin
                        pulse_req(4'(1 << a));
                        if (svc == 1) do_ack();
                        pulse_req(4'(1 << b));
                        if (b < a) begin
                            check("R8 reset pulse", int'(rst_req), 1);
                            check("R8 flag set", int'(trap_rst_flag), 1);
                            check("R8 flushed valid", int'(trap_valid), 0);
                            check("R8 flushed stall", int'(cpu_stall), 0);
                            @(negedge clk);
                            check("R8 single pulse", int'(rst_req), 0);
                            check("R10 flag survives", int'(trap_rst_flag), 1);
                            wr_sts(1'b0);
                            check("R10 write zero clears", int'(trap_rst_flag), 0);
                            do_done();
                            check("R8 nothing left", int'(trap_valid), 0);
                        end else begin
                            check("R9 no reset", int'(rst_req), 0);
                            check("R9 higher presented", int'(trap_vec), b + 3);
                            check("R9 flag clear", int'(trap_rst_flag), 0);
                            drain();
                        end
                    end
                end
            end
        end

        // R6: hard preempts soft in service and soft pending.
        pulse_req(4'b0001);
        check("R5 soft no stall", int'(cpu_stall), 0);
        do_ack();
        pulse_req(4'b0010);
        check("R6 no conflict svc", int'(rst_req), 0);
        check("R6 hard presented", int'(trap_vec), 4);
        check("R6 stall", int'(cpu_stall), 1);
        drain();
        pulse_req(4'b0001);
        pulse_req(4'b0100);
        check("R6 no conflict pend", int'(rst_req), 0);
        check("R6 stack presented", int'(trap_vec), 5);
        drain();
        check("R6 flag untouched", int'(trap_rst_flag), 0);

        // R11: an acknowledge with nothing presented is ignored.
        pulse_req(4'b0010);
        do_ack();
        pulse_req(4'b0001);
        check("R11 soft held back", int'(trap_valid), 0);
        do_ack();
        do_done();
        check("R11 soft still pending", int'(trap_valid), 1);
        check("R11 soft vector", int'(trap_vec), 3);
        drain();

        // R10: write rules of the flag.
        pulse_req(4'b1000);
        pulse_req(4'b0010);
        check("R8 osc then addr", int'(rst_req), 1);
        wr_sts(1'b1);
        check("R10 write one keeps", int'(trap_rst_flag), 1);
        wr_sts(1'b0);
        check("R10 cleared", int'(trap_rst_flag), 0);
        pulse_req(4'b1000);
        trap_req = 4'b0100;
        sts_wr = 1'b1;
        sts_wdata = 1'b0;
        @(negedge clk);
        trap_req = '0;
        sts_wr = 1'b0;
        check("R10 set beats clear", int'(trap_rst_flag), 1);
        wr_sts(1'b0);
        check("R10 final clear", int'(trap_rst_flag), 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule